// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single DMA channel that moves data between memory and one fixed peripheral. It holds two buffer slots, A and B, each with a start address and a byte count. While one slot is being drained, software refills the other. When the active slot finishes, the channel switches to the other slot on its own. If that slot is already armed, it keeps going with no software involvement, so a stream of buffers flows without a gap.

Software controls the channel through a 32-byte register window. The control/status word can be reached through three views. The set view turns bits on wherever a one is written. The clear view turns bits off wherever a one is written. The read view returns the word unchanged. This lets software arm a slot, pause the channel or acknowledge a completion with one write, without a read-modify-write race against the hardware.

Each peripheral request starts a burst of 4 or 8 units on a simple request/acknowledge word port toward memory. A unit is 8 or 16 bits wide. The direction is fixed by configuration: either memory writes fed from the peripheral data input, or memory reads delivered to the peripheral data output. An interrupt output summarises completion and error status.

Top module: `pingpong_dma_chan`

## Requirements
- R1: After a synchronous active-low reset, the following all read as zero: the configuration word, the control/status word, both slot addresses and both slot counts. `mem_req` and `irq` are low.
- R2: Registers are decoded from `reg_addr[4:2]` when `reg_addr[1:0]` is 0. The map is: 0 configuration (bits 7:0), 1 set view, 2 clear view, 3 read view, 4 slot A address, 5 slot A count, 6 slot B address, 7 slot B count. Views 1 to 3 all read the status word, and a misaligned address reads 0 and ignores writes. Configuration bits: 0 = peripheral-to-memory, 1 = byte swap, 2 = 8-beat burst (else 4), 3 = 16-bit units (else 8), 7:4 = peripheral select (stored only).
- R3: Status bits are: 0 run, 1 interrupt enable, 2 error, 3 A done, 4 A armed, 5 B done, 6 B armed, 7 active slot (1 = B). A one written to the set view sets bits 6:0, and a one written to the clear view clears them. Zeros have no effect, and bit 7 ignores both views.
- R4: `irq` is high exactly when interrupt enable is set and at least one of error, A done or B done is set.
- R5: When the active slot finishes, its armed bit clears, its done bit sets and bit 7 flips. The other slot then starts bursting on the next peripheral request if it is armed.
- R6: `mem_req` is high only while run is set and the active slot is armed. A request seen while idle starts a burst of 4 or 8 beats, and the burst ends early when the count reaches zero.
- R7: Writes to a slot address force bits 1:0 to zero. Writes to a slot count keep only bits 12:0.
- R8: Each accepted beat without error advances the active slot address by the unit size (1 or 2 bytes). It lowers the count by the unit size, stopping at zero. `mem_addr` always shows the active slot address, and `per_stb` pulses once per such beat.
- R9: Clearing run drops `mem_req` at once and keeps all slot state, including the beats left in the burst. Setting run again resumes from the same address and count.
- R10: A beat acknowledged with `mem_err` sets error and clears run. It ends the burst and leaves the slot address and count unchanged.
- R11: `mem_we` equals configuration bit 0 and `mem_wide` equals bit 3. The data lanes apply to both `mem_wdata` (from `per_rdata`) and `per_wdata` (from `mem_rdata`). In 16-bit mode a lane passes its data through, or swaps the two bytes when bit 1 is set. In 8-bit mode a lane passes the low byte and zeroes the high byte.
- R12: An armed active slot whose count is zero finishes one cycle after run and armed are both seen, with no bus request, and with the same status effects as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address within the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| per_req | input | 1 | Peripheral burst request (level) |
| per_rdata | input | 16 | Data from peripheral (peripheral-to-memory) |
| per_wdata | output | 16 | Data to peripheral (memory-to-peripheral), valid with per_stb |
| per_stb | output | 1 | One unit transferred this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a memory write |
| mem_wide | output | 1 | Beat is 16 bits (else 8) |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Beat accepted this cycle |
| mem_err | input | 1 | Beat failed, qualified by mem_ack |
| irq | output | 1 | Channel interrupt |

## Verification
A register write lands on the clock edge that samples it, so the read view and `irq` show the new value in the very next cycle. Beat effects on address, count and status follow the same timing, one cycle after the acknowledging edge. A peripheral request seen in the idle cycle raises `mem_req` one cycle later, and a zero-count slot finishes one cycle after it becomes armed and running. The bench updates its behavioural model at the same rising edge the design uses, with inputs changed 1 ns after the edge. It then compares every output and the read-back of the currently addressed register at the following falling edge, so each result is checked in the cycle it falls due.

// File: rtl/dma_chan_pkg.sv
// Shared constants and types for the double-buffered DMA channel.
// Assumes a 32-byte register window with word-aligned registers.
package dma_chan_pkg;
    localparam int unsigned SB_RUN    = 0;
    localparam int unsigned SB_IE     = 1;
    localparam int unsigned SB_ERR    = 2;
    localparam int unsigned SB_DONE_A = 3;
    localparam int unsigned SB_GO_A   = 4;
    localparam int unsigned SB_DONE_B = 5;
    localparam int unsigned SB_GO_B   = 6;
    localparam int unsigned SB_SLOT   = 7;

    localparam logic [2:0] IX_CFG  = 3'd0;
    localparam logic [2:0] IX_SET  = 3'd1;
    localparam logic [2:0] IX_CLR  = 3'd2;
    localparam logic [2:0] IX_STAT = 3'd3;
    localparam logic [2:0] IX_SLOT = 3'd4;   // slot s: address at 4+2s, count at 5+2s

    typedef struct packed {
        logic [3:0] psel;
        logic       wide;
        logic       burst8;
        logic       swap;
        logic       to_mem;
    } chan_cfg_t;

    function automatic int unsigned go_bit(input logic slot);
        return slot ? SB_GO_B : SB_GO_A;
    endfunction

    function automatic int unsigned done_bit(input logic slot);
        return slot ? SB_DONE_B : SB_DONE_A;
    endfunction
endpackage

// File: rtl/dma_chan_lane.sv
// Data lane: formats one unit for the configured width and byte order.
// Assumes UW is even; narrow mode uses the low half only.
module dma_chan_lane #(
    parameter int UW = 16
) (
    input  logic          wide,
    input  logic          swap,
    input  logic [UW-1:0] din,
    output logic [UW-1:0] dout
);
    localparam int HW = UW / 2;

    // Pick pass-through, half swap or zero-extended low half.
    always_comb begin
        if (!wide)
            dout = {{HW{1'b0}}, din[HW-1:0]};
        else if (swap)
            dout = {din[HW-1:0], din[UW-1:HW]};
        else
            dout = din;
    end
endmodule

// File: rtl/dma_chan_csr.sv
// Register file of the channel: configuration, status word with set and
// clear views, and the two slot address/count pairs. Software writes take
// priority over same-cycle hardware updates. Assumes AW <= 32.
module dma_chan_csr
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [4:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          hw_adv,
    input  logic [AW-1:0] hw_addr,
    input  logic [CW-1:0] hw_cnt,
    input  logic          hw_fin,
    input  logic          hw_err,
    output chan_cfg_t     cfg,
    output logic [7:0]    stat,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt
);
    logic          hit;
    logic [2:0]    idx;
    logic [7:0]    hw_set, hw_clr, mid, stat_d;
    logic [6:0]    sw_set, sw_clr;
    logic [AW-1:0] sa_q [2];
    logic [CW-1:0] cnt_q [2];

    assign hit = reg_we && (reg_addr[1:0] == 2'b00);
    assign idx = reg_addr[4:2];

    // Configuration word register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (hit && idx == IX_CFG)
            cfg <= chan_cfg_t'(reg_wdata[7:0]);
    end

    // Status next value: hardware effects first, then software views.
    always_comb begin
        hw_set = '0;
        hw_clr = '0;
        if (hw_err) begin
            hw_set[SB_ERR] = 1'b1;
            hw_clr[SB_RUN] = 1'b1;
        end
        if (hw_fin) begin
            hw_clr[go_bit(stat[SB_SLOT])]   = 1'b1;
            hw_set[done_bit(stat[SB_SLOT])] = 1'b1;
            hw_set[SB_SLOT] = ~stat[SB_SLOT];
            hw_clr[SB_SLOT] = stat[SB_SLOT];
        end
        mid    = (stat & ~hw_clr) | hw_set;
        sw_set = (hit && idx == IX_SET) ? reg_wdata[6:0] : '0;
        sw_clr = (hit && idx == IX_CLR) ? reg_wdata[6:0] : '0;
        stat_d = {mid[7], (mid[6:0] | sw_set) & ~sw_clr};
    end

    // Status word register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat <= '0;
        else
            stat <= stat_d;
    end

    // One address/count pair per slot; the active one follows the mover.
    for (genvar s = 0; s < 2; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sa_q[s]  <= '0;
                cnt_q[s] <= '0;
            end else begin
                if (hit && idx == IX_SLOT + 3'(2*s))
                    sa_q[s] <= {reg_wdata[AW-1:2], 2'b00};
                else if (hw_adv && stat[SB_SLOT] == 1'(s))
                    sa_q[s] <= hw_addr;
                if (hit && idx == IX_SLOT + 3'(2*s+1))
                    cnt_q[s] <= reg_wdata[CW-1:0];
                else if (hw_adv && stat[SB_SLOT] == 1'(s))
                    cnt_q[s] <= hw_cnt;
            end
        end
    end

    assign cur_addr = sa_q[stat[SB_SLOT]];
    assign cur_cnt  = cnt_q[stat[SB_SLOT]];

    // Read mux over the window.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr[1:0] == 2'b00) begin
            case (idx)
                IX_CFG:                 reg_rdata = {24'd0, cfg};
                IX_SET, IX_CLR, IX_STAT: reg_rdata = {24'd0, stat};
                3'd4:                   reg_rdata = 32'(sa_q[0]);
                3'd5:                   reg_rdata = 32'(cnt_q[0]);
                3'd6:                   reg_rdata = 32'(sa_q[1]);
                default:                reg_rdata = 32'(cnt_q[1]);
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_mover.sv
// Burst engine: waits for a peripheral request while the active slot is
// armed and running, then issues up to BURST_LO/BURST_HI beats, one per
// acknowledge. Keeps the beats left across a pause. Assumes mem_err is
// only meaningful together with mem_ack.
module dma_chan_mover #(
    parameter int AW       = 32,
    parameter int CW       = 13,
    parameter int BURST_LO = 4,
    parameter int BURST_HI = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cur_go,
    input  logic          wide,
    input  logic          burst8,
    input  logic [AW-1:0] cur_addr,
    input  logic [CW-1:0] cur_cnt,
    input  logic          per_req,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          mem_req,
    output logic          adv,
    output logic [AW-1:0] nxt_addr,
    output logic [CW-1:0] nxt_cnt,
    output logic          fin,
    output logic          err
);
    localparam int BW = $clog2(BURST_HI + 1);
    localparam logic [BW-1:0] N_LO = BW'(BURST_LO);
    localparam logic [BW-1:0] N_HI = BW'(BURST_HI);

    logic          busy;
    logic [BW-1:0] left;
    logic          live, beat;
    logic [CW-1:0] step_c;

    assign live     = run && cur_go;
    assign mem_req  = busy && live;
    assign beat     = mem_req && mem_ack;
    assign err      = beat && mem_err;
    assign adv      = beat && !mem_err;
    assign step_c   = wide ? CW'(2) : CW'(1);
    assign nxt_addr = cur_addr + (wide ? AW'(2) : AW'(1));
    assign nxt_cnt  = (cur_cnt <= step_c) ? '0 : cur_cnt - step_c;
    assign fin      = (!busy && live && cur_cnt == '0) || (adv && nxt_cnt == '0);

    // Burst state: start on request, count beats, stop on end, error or disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            left <= '0;
        end else if (!busy) begin
            if (live && cur_cnt != '0 && per_req) begin
                busy <= 1'b1;
                left <= burst8 ? N_HI : N_LO;
            end
        end else if (!cur_go || err) begin
            busy <= 1'b0;
        end else if (adv) begin
            left <= left - 1'b1;
            if (nxt_cnt == '0 || left == BW'(1))
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/pingpong_dma_chan.sv
// Top of the double-buffered DMA channel: register file, burst engine and
// the two data lanes. The memory port is a single-beat request/acknowledge
// port; the peripheral side is a level request plus data in and out.
module pingpong_dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CW       = 13,
    parameter int UW       = 16,
    parameter int BURST_LO = 4,
    parameter int BURST_HI = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [4:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          per_req,
    input  logic [UW-1:0] per_rdata,
    output logic [UW-1:0] per_wdata,
    output logic          per_stb,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_wide,
    output logic [AW-1:0] mem_addr,
    output logic [UW-1:0] mem_wdata,
    input  logic [UW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          irq
);
    chan_cfg_t     cfg;
    logic [7:0]    stat_w;
    logic [AW-1:0] cur_addr, nxt_addr;
    logic [CW-1:0] cur_cnt, nxt_cnt;
    logic          adv, fin, err;

    dma_chan_csr #(.AW(AW), .CW(CW)) u_csr (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_adv(adv), .hw_addr(nxt_addr), .hw_cnt(nxt_cnt),
        .hw_fin(fin), .hw_err(err),
        .cfg(cfg), .stat(stat_w), .cur_addr(cur_addr), .cur_cnt(cur_cnt)
    );

    dma_chan_mover #(.AW(AW), .CW(CW), .BURST_LO(BURST_LO), .BURST_HI(BURST_HI)) u_mover (
        .clk(clk), .rst_n(rst_n),
        .run(stat_w[SB_RUN]), .cur_go(stat_w[go_bit(stat_w[SB_SLOT])]),
        .wide(cfg.wide), .burst8(cfg.burst8),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt),
        .per_req(per_req), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_req(mem_req), .adv(adv), .nxt_addr(nxt_addr), .nxt_cnt(nxt_cnt),
        .fin(fin), .err(err)
    );

    dma_chan_lane #(.UW(UW)) u_lane_wr (
        .wide(cfg.wide), .swap(cfg.swap), .din(per_rdata), .dout(mem_wdata)
    );

    dma_chan_lane #(.UW(UW)) u_lane_rd (
        .wide(cfg.wide), .swap(cfg.swap), .din(mem_rdata), .dout(per_wdata)
    );

    assign mem_we   = cfg.to_mem;
    assign mem_wide = cfg.wide;
    assign mem_addr = cur_addr;
    assign per_stb  = adv;
    assign irq      = stat_w[SB_IE] &&
                      (stat_w[SB_ERR] || stat_w[SB_DONE_A] || stat_w[SB_DONE_B]);
endmodule

// File: rtl/dma_chan_checker.sv
// Temporal checks on the channel, attached to the top module by bind.
module dma_chan_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_err,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    stat_w
);
    // R9: no beat is requested while the channel is paused.
    p_req_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> stat_w[0]);

    // R6: a request always targets an armed slot.
    p_req_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (stat_w[7] ? stat_w[6] : stat_w[4]));

    // R8: the beat address holds while a beat waits for its acknowledge.
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !reg_we) |=> $stable(mem_addr));

    // R10: an error response stops the channel and flags error.
    p_err_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err && !reg_we) |=> (stat_w[2] && !stat_w[0]));

    // R5: the active slot flips only as the finished slot is disarmed.
    p_slot_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(stat_w[7]) && !$past(reg_we)) |->
            ($past(stat_w[7]) ? $fell(stat_w[6]) : $fell(stat_w[4])));
endmodule

bind pingpong_dma_chan dma_chan_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_addr(mem_addr), .stat_w(stat_w)
);

// File: tb/pingpong_dma_chan_bench.sv
`timescale 1ns/1ps
module pingpong_dma_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic [15:0] per_rdata = 16'hA1B2;
    logic [15:0] per_wdata;
    logic        per_stb;
    logic        mem_req, mem_we, mem_wide;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        mem_ack, mem_err, irq;
    logic        ack_en = 1'b0, err_en = 1'b0;
    int          n_chk = 0, n_err = 0, cyc = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pingpong_dma_chan u_pingpong_dma_chan (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_rdata(per_rdata), .per_wdata(per_wdata), .per_stb(per_stb),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
    );

    // Memory responder: answers every request in the same cycle.
    assign mem_ack   = mem_req & ack_en;
    assign mem_err   = mem_req & err_en;
    assign mem_rdata = mem_addr[15:0] ^ 16'h5A0F;

    // Peripheral data source changes every edge.
    always @(posedge clk) per_rdata <= per_rdata + 16'h0137;

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_cfg, m_st;
    logic [31:0] m_sa [2];
    int          m_cnt [2];
    bit          m_busy;
    int          m_beats;

    function automatic logic [15:0] lane_exp(input logic [15:0] d, input logic [7:0] c);
        if (!c[3]) return {8'h00, d[7:0]};
        if (c[1])  return {d[7:0], d[15:8]};
        return d;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[4:2])
            3'd0: return {24'h0, m_cfg};
            3'd1, 3'd2, 3'd3: return {24'h0, m_st};
            3'd4: return m_sa[0];
            3'd5: return 32'(m_cnt[0]);
            3'd6: return m_sa[1];
            default: return 32'(m_cnt[1]);
        endcase
    endfunction

    always @(posedge clk) begin
        int  b, gb, dbit, ub;
        bit  fin;
        if (!rst_n) begin
            m_cfg = 0; m_st = 0; m_sa[0] = 0; m_sa[1] = 0;
            m_cnt[0] = 0; m_cnt[1] = 0; m_busy = 0; m_beats = 0;
        end else begin
            b    = m_st[7] ? 1 : 0;
            gb   = b ? 6 : 4;
            dbit = b ? 5 : 3;
            ub   = m_cfg[3] ? 2 : 1;
            fin  = 0;
            if (!m_busy) begin
                if (m_st[0] && m_st[gb] && m_cnt[b] == 0) fin = 1;
                else if (m_st[0] && m_st[gb] && per_req) begin
                    m_busy = 1; m_beats = m_cfg[2] ? 8 : 4;
                end
            end else if (!m_st[gb]) begin
                m_busy = 0;
            end else if (m_st[0] && ack_en) begin
                if (err_en) begin
                    m_st[2] = 1; m_st[0] = 0; m_busy = 0;
                end else begin
                    m_sa[b]  = m_sa[b] + ub;
                    m_cnt[b] = (m_cnt[b] <= ub) ? 0 : m_cnt[b] - ub;
                    m_beats  = m_beats - 1;
                    if (m_cnt[b] == 0) begin fin = 1; m_busy = 0; end
                    else if (m_beats == 0) m_busy = 0;
                end
            end
            if (fin) begin m_st[gb] = 0; m_st[dbit] = 1; m_st[7] = ~m_st[7]; end
            if (reg_we && reg_addr[1:0] == 2'b00) begin
                case (reg_addr[4:2])
                    3'd0: m_cfg = reg_wdata[7:0];
                    3'd1: m_st[6:0] = m_st[6:0] | reg_wdata[6:0];
                    3'd2: m_st[6:0] = m_st[6:0] & ~reg_wdata[6:0];
                    3'd4: m_sa[0] = reg_wdata & ~32'h3;
                    3'd5: m_cnt[0] = int'(reg_wdata & 32'h1FFF);
                    3'd6: m_sa[1] = reg_wdata & ~32'h3;
                    3'd7: m_cnt[1] = int'(reg_wdata & 32'h1FFF);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare every output against the model at the falling edge.
    always @(negedge clk) begin
        bit e_req;
        if (rst_n && !done) begin
            e_req = m_busy && m_st[0] && (m_st[7] ? m_st[6] : m_st[4]);
            chk("R6 mem_req", 32'(mem_req), 32'(e_req));
            chk("R8 mem_addr", mem_addr, m_sa[m_st[7]]);
            chk("R11 mem_we", 32'(mem_we), 32'(m_cfg[0]));
            chk("R11 mem_wide", 32'(mem_wide), 32'(m_cfg[3]));
            chk("R4 irq", 32'(irq), 32'(m_st[1] && (m_st[2] || m_st[3] || m_st[5])));
            chk("R2 reg_rdata", reg_rdata, m_read(reg_addr));
            chk("R8 per_stb", 32'(per_stb), 32'(e_req && ack_en && !err_en));
            if (e_req) chk("R11 mem_wdata", 32'(mem_wdata), 32'(lane_exp(per_rdata, m_cfg)));
            if (per_stb)
                chk("R11 per_wdata", 32'(per_wdata),
                    32'(lane_exp(m_sa[m_st[7]][15:0] ^ 16'h5A0F, m_cfg)));
        end
    end

    task automatic clk_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_err++;
            $display("FAIL R9 watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        clk_n(4);
        rst_n = 1'b1;
        // R1: reset state of every register and the outputs.
        for (int i = 0; i < 8; i++) rd(5'(4*i), 32'h0, "R1 reset register");
        @(negedge clk);
        chk("R1 reset mem_req", 32'(mem_req), 32'h0);
        chk("R1 reset irq", 32'(irq), 32'h0);

        // R2/R7: configuration and slot programming.
        wr(5'h00, 32'h0B);
        rd(5'h00, 32'h0B, "R2 config readback");
        rd(5'h02, 32'h0, "R2 misaligned read");
        wr(5'h10, 32'h1003);
        rd(5'h10, 32'h1000, "R7 address alignment");
        wr(5'h14, 32'hFFFF);
        rd(5'h14, 32'h1FFF, "R7 count mask");
        wr(5'h14, 32'd12);
        wr(5'h18, 32'h2000);
        wr(5'h1C, 32'd4);

        // R3: set view, bit 7 ignored, zero writes harmless.
        wr(5'h04, 32'hD2);
        rd(5'h0C, 32'h52, "R3 set view");
        wr(5'h04, 32'h00);
        wr(5'h08, 32'h00);
        rd(5'h04, 32'h52, "R3 zero writes");
        ack_en = 1'b1; per_req = 1'b1;
        clk_n(3);
        @(negedge clk);
        chk("R6 no request while stopped", 32'(mem_req), 32'h0);

        // R5/R8: run both slots back to back.
        wr(5'h04, 32'h01);
        clk_n(30);
        rd(5'h0C, 32'h2B, "R5 both slots done, slot A active");
        rd(5'h10, 32'h100C, "R8 slot A position");
        rd(5'h14, 32'h0, "R8 slot A count");
        rd(5'h18, 32'h2004, "R8 slot B position");
        @(negedge clk);
        chk("R4 irq on done", 32'(irq), 32'h1);

        // R4: interrupt combinations.
        wr(5'h08, 32'h08);
        @(negedge clk); chk("R4 irq with B done", 32'(irq), 32'h1);
        wr(5'h08, 32'h20);
        @(negedge clk); chk("R4 irq cleared", 32'(irq), 32'h0);
        wr(5'h08, 32'h02);
        wr(5'h04, 32'h08);
        @(negedge clk); chk("R4 irq masked", 32'(irq), 32'h0);
        wr(5'h04, 32'h02);
        @(negedge clk); chk("R4 irq enabled", 32'(irq), 32'h1);
        wr(5'h08, 32'h0A);
        rd(5'h0C, 32'h01, "R3 clear view");

        // R9: pause and resume inside an 8-beat byte burst.
        per_req = 1'b0;
        wr(5'h00, 32'h04);
        wr(5'h10, 32'h3000);
        wr(5'h14, 32'd20);
        wr(5'h04, 32'h10);
        per_req = 1'b1;
        clk_n(3);
        per_req = 1'b0;
        clk_n(1);
        wr(5'h08, 32'h01);
        clk_n(5);
        @(negedge clk);
        chk("R9 paused no request", 32'(mem_req), 32'h0);
        wr(5'h04, 32'h01);
        per_req = 1'b1;
        clk_n(30);
        rd(5'h10, 32'h3014, "R9 resumed to end address");
        rd(5'h14, 32'h0, "R9 resumed to zero count");
        rd(5'h0C, 32'h89, "R5 slot B now active");

        // R12: zero-count slot finishes without traffic.
        wr(5'h04, 32'h40);
        clk_n(3);
        rd(5'h0C, 32'h29, "R12 zero count completes");
        rd(5'h18, 32'h2004, "R12 no address movement");

        // R10: bus error.
        wr(5'h08, 32'h28);
        wr(5'h00, 32'h09);
        wr(5'h10, 32'h4000);
        wr(5'h14, 32'd8);
        err_en = 1'b1;
        wr(5'h04, 32'h10);
        clk_n(5);
        rd(5'h0C, 32'h14, "R10 error sets, run clears");
        rd(5'h10, 32'h4000, "R10 address kept");
        rd(5'h14, 32'd8, "R10 count kept");
        @(negedge clk); chk("R4 irq masked on error", 32'(irq), 32'h0);
        wr(5'h04, 32'h02);
        @(negedge clk); chk("R4 irq on error", 32'(irq), 32'h1);
        err_en = 1'b0;
        wr(5'h08, 32'h04);
        wr(5'h04, 32'h01);
        clk_n(15);
        rd(5'h14, 32'h0, "R10 retry completes");
        rd(5'h10, 32'h4008, "R10 retry end address");
        rd(5'h0C, 32'h8B, "R5 status after retry");

        clk_n(2);
        finish_run();
    end
endmodule